// File: doc/BRIEF.md
# Reservation-based atomic load/store unit

This block carries out the two halves of a reservation-based atomic sequence for one hart: a reserving load and a conditional store. The core hands it one decoded operation at a time. The operation carries its kind, access width, ordering bits, physical address, store data and destination register index. The block checks that the address is naturally aligned and keeps a single reservation. It talks to a memory port that has request/response signalling, a fault flag and a "write took place" flag. For each operation it returns exactly one result: either a retirement with a register writeback, or a trap with a cause code and a trap value.

A reserving load that completes records the address it read and marks the reservation valid. A conditional store is attempted in memory only when the reservation is valid and holds exactly the same address. Any conditional store, whatever its outcome, drops the reservation. An external clear input lets the surrounding logic drop the reservation at any time. The register width is a parameter. When it is 32, a doubleword access is an illegal instruction.

Top module: `lrsc_unit`

## Requirements
- R1: The width code is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword. A byte is always aligned. A halfword needs address bit 0 clear, a word needs bits 1:0 clear and a doubleword needs bits 2:0 clear. A misaligned reserving load traps with cause 4 and trap value equal to the address. It makes no memory request and does no writeback, and its result appears in the cycle after acceptance.
- R2: A misaligned conditional store traps with cause 6 and trap value equal to the address, with no memory request.
- R3: A conditional store whose reservation is invalid retires in the cycle after acceptance. It writes 1 to its destination and makes no memory request.
- R4: A conditional store that hits the reservation issues a write (mem_we=1). It writes 0 to its destination when mem_rsp_done=1 and 1 when mem_rsp_done=0.
- R5: Every conditional store leaves the reservation invalid, so an immediately following conditional store to the same address fails without a memory request.
- R6: A reserving load returns the loaded value of its width, sign-extended to XLEN, in res_wdata. On success it records its address as a valid reservation.
- R7: A memory fault (mem_rsp_err=1) traps with cause 5 for a reserving load and cause 7 for a conditional store. The trap value is the address, and there is no writeback.
- R8: A conditional store drives mem_size equal to its width code and mem_wdata equal to the low 8, 16, 32 or 64 bits of the store data, with the upper bits zero.
- R9: A reserving load drives mem_acq=aq and mem_rel=aq AND rl. A conditional store drives mem_acq=aq AND rl and mem_rel=rl.
- R10: A one-cycle pulse on resv_clear invalidates the reservation.
- R11: With XLEN=32, a doubleword operation traps with cause 2 and trap value 0, without a memory request.
- R12: mem_req rises in the cycle after acceptance and holds its address and data until the cycle mem_rsp_valid is seen. busy is high throughout that time. res_valid pulses for one cycle, in the cycle after the response.
- R13: The reservation hits only on an exact address match. A conditional store to another aligned address fails without a memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation offered; taken when busy is low |
| req_is_sc | input | 1 | 1 = conditional store, 0 = reserving load |
| req_width | input | 2 | Width code (0 byte, 1 half, 2 word, 3 double) |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| req_addr | input | XLEN | Physical address |
| req_wdata | input | XLEN | Store data |
| req_rd | input | RD_W | Destination register index |
| busy | output | 1 | A memory access is outstanding |
| resv_clear | input | 1 | Invalidate the reservation |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Memory address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | XLEN | Write data, zero above the width |
| mem_acq | output | 1 | Acquire attribute |
| mem_rel | output | 1 | Release attribute |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_err | input | 1 | Access fault |
| mem_rsp_done | input | 1 | Write took place |
| mem_rdata | input | XLEN | Read data, right-aligned |
| res_valid | output | 1 | One-cycle result strobe |
| res_trap | output | 1 | Result is a trap |
| res_cause | output | 4 | Trap cause |
| res_tval | output | XLEN | Trap value |
| res_wb_en | output | 1 | Destination write enable |
| res_rd | output | RD_W | Destination index |
| res_wdata | output | XLEN | Destination value |

## Verification
A reservation that stays valid when it should not shows up at the next conditional store to that address. That store raises mem_req where none was due, one cycle after acceptance. A reservation lost or stored at the wrong address shows up as a writeback of 1 with no memory request. Wrong alignment decoding or sign extension shows on the result strobe one cycle after acceptance or one cycle after the response. The directed sequences therefore always pair a reservation change with an immediate follow-up conditional store.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } lrsc_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } lrsc_state_e;

   localparam int CAUSE_W = 4;
   localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
   localparam logic [CAUSE_W-1:0] CAUSE_LD_MISAL = 4'd4;
   localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT = 4'd5;
   localparam logic [CAUSE_W-1:0] CAUSE_ST_MISAL = 4'd6;
   localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT = 4'd7;
endpackage

// File: rtl/lrsc_align_chk.sv
module lrsc_align_chk
   import lrsc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [1:0] size,
   input  logic [2:0] addr_lo,
   output logic       misaligned,
   output logic       illegal_size
);
   logic [2:0] low_mask;

   always_comb begin
      case (size)
         SZ_B:    low_mask = 3'b000;
         SZ_H:    low_mask = 3'b001;
         SZ_W:    low_mask = 3'b011;
         default: low_mask = 3'b111;
      endcase
   end

   assign misaligned = |(addr_lo & low_mask);

   generate
      if (XLEN == 32) begin : g_narrow
         assign illegal_size = (size == SZ_D);
      end else begin : g_wide
         assign illegal_size = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
   parameter int AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set,
   input  logic [AW-1:0] set_addr,
   input  logic          kill,
   input  logic [AW-1:0] probe_addr,
   output logic          valid_o,
   output logic          hit_o
);
   logic [AW-1:0] held_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         held_addr <= '0;
      end else if (set) begin
         valid_o   <= 1'b1;
         held_addr <= set_addr;
      end else if (kill) begin
         valid_o   <= 1'b0;
      end
   end

   assign hit_o = valid_o && (held_addr == probe_addr);
endmodule

// File: rtl/lrsc_lane_fmt.sv
module lrsc_lane_fmt
   import lrsc_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [1:0]      ld_size,
   input  logic [XLEN-1:0] ld_raw,
   output logic [XLEN-1:0] ld_ext,
   input  logic [1:0]      st_size,
   input  logic [XLEN-1:0] st_raw,
   output logic [XLEN-1:0] st_out
);
   logic [XLEN-1:0] st_mask;

   always_comb begin
      if (st_size == SZ_D) st_mask = '1;
      else                 st_mask = (XLEN'(1) << (8 << st_size)) - XLEN'(1);
   end
   assign st_out = st_raw & st_mask;

   generate
      if (XLEN == 64) begin : g_x64
         always_comb begin
            case (ld_size)
               SZ_B:    ld_ext = {{(XLEN-8){ld_raw[7]}}, ld_raw[7:0]};
               SZ_H:    ld_ext = {{(XLEN-16){ld_raw[15]}}, ld_raw[15:0]};
               SZ_W:    ld_ext = {{(XLEN-32){ld_raw[31]}}, ld_raw[31:0]};
               default: ld_ext = ld_raw;
            endcase
         end
      end else begin : g_x32
         always_comb begin
            case (ld_size)
               SZ_B:    ld_ext = {{(XLEN-8){ld_raw[7]}}, ld_raw[7:0]};
               SZ_H:    ld_ext = {{(XLEN-16){ld_raw[15]}}, ld_raw[15:0]};
               default: ld_ext = ld_raw;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
   import lrsc_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int RD_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_is_sc,
   input  logic [1:0]         req_width,
   input  logic               req_aq,
   input  logic               req_rl,
   input  logic [XLEN-1:0]    req_addr,
   input  logic [XLEN-1:0]    req_wdata,
   input  logic [RD_W-1:0]    req_rd,
   output logic               busy,
   input  logic               resv_clear,
   output logic               mem_req,
   output logic               mem_we,
   output logic [XLEN-1:0]    mem_addr,
   output logic [1:0]         mem_size,
   output logic [XLEN-1:0]    mem_wdata,
   output logic               mem_acq,
   output logic               mem_rel,
   input  logic               mem_rsp_valid,
   input  logic               mem_rsp_err,
   input  logic               mem_rsp_done,
   input  logic [XLEN-1:0]    mem_rdata,
   output logic               res_valid,
   output logic               res_trap,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [XLEN-1:0]    res_tval,
   output logic               res_wb_en,
   output logic [RD_W-1:0]    res_rd,
   output logic [XLEN-1:0]    res_wdata
);
   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("lrsc_unit: XLEN must be 32 or 64");
      end
      if (RD_W < 1) begin : g_bad_rdw
         $error("lrsc_unit: RD_W must be positive");
      end
   endgenerate

   lrsc_state_e      state;
   logic             cur_is_sc;
   logic [1:0]       cur_size;
   logic [XLEN-1:0]  cur_addr;
   logic             accept;
   logic             rsp_seen;
   logic             misaligned;
   logic             illegal_size;
   logic             resv_valid;
   logic             resv_hit;
   logic [XLEN-1:0]  ld_ext;
   logic [XLEN-1:0]  st_masked;

   assign busy     = (state == ST_WAIT);
   assign accept   = req_valid && (state == ST_IDLE);
   assign rsp_seen = (state == ST_WAIT) && mem_rsp_valid;

   lrsc_align_chk #(.XLEN(XLEN)) u_align (
      .size         (req_width),
      .addr_lo      (req_addr[2:0]),
      .misaligned   (misaligned),
      .illegal_size (illegal_size)
   );

   lrsc_resv #(.AW(XLEN)) u_resv (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (rsp_seen && !mem_rsp_err && !cur_is_sc),
      .set_addr   (cur_addr),
      .kill       (resv_clear || (accept && req_is_sc)),
      .probe_addr (req_addr),
      .valid_o    (resv_valid),
      .hit_o      (resv_hit)
   );

   lrsc_lane_fmt #(.XLEN(XLEN)) u_lane (
      .ld_size (cur_size),
      .ld_raw  (mem_rdata),
      .ld_ext  (ld_ext),
      .st_size (req_width),
      .st_raw  (req_wdata),
      .st_out  (st_masked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_is_sc <= 1'b0;
         cur_size  <= '0;
         cur_addr  <= '0;
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_size  <= '0;
         mem_wdata <= '0;
         mem_acq   <= 1'b0;
         mem_rel   <= 1'b0;
         res_valid <= 1'b0;
         res_trap  <= 1'b0;
         res_cause <= '0;
         res_tval  <= '0;
         res_wb_en <= 1'b0;
         res_rd    <= '0;
         res_wdata <= '0;
      end else begin
         res_valid <= 1'b0;
         if (accept) begin
            cur_is_sc <= req_is_sc;
            cur_size  <= req_width;
            cur_addr  <= req_addr;
            res_rd    <= req_rd;
            if (illegal_size) begin
               res_valid <= 1'b1;
               res_trap  <= 1'b1;
               res_cause <= CAUSE_ILLEGAL;
               res_tval  <= '0;
               res_wb_en <= 1'b0;
            end else if (misaligned) begin
               res_valid <= 1'b1;
               res_trap  <= 1'b1;
               res_cause <= req_is_sc ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
               res_tval  <= req_addr;
               res_wb_en <= 1'b0;
            end else if (req_is_sc && !resv_hit) begin
               res_valid <= 1'b1;
               res_trap  <= 1'b0;
               res_wb_en <= 1'b1;
               res_wdata <= XLEN'(1);
            end else begin
               state     <= ST_WAIT;
               mem_req   <= 1'b1;
               mem_we    <= req_is_sc;
               mem_addr  <= req_addr;
               mem_size  <= req_width;
               mem_wdata <= req_is_sc ? st_masked : '0;
               mem_acq   <= req_is_sc ? (req_aq && req_rl) : req_aq;
               mem_rel   <= req_is_sc ? req_rl : (req_aq && req_rl);
            end
         end else if (rsp_seen) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            res_valid <= 1'b1;
            if (mem_rsp_err) begin
               res_trap  <= 1'b1;
               res_cause <= cur_is_sc ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
               res_tval  <= cur_addr;
               res_wb_en <= 1'b0;
            end else begin
               res_trap  <= 1'b0;
               res_wb_en <= 1'b1;
               res_wdata <= cur_is_sc ? XLEN'(!mem_rsp_done) : ld_ext;
            end
         end
      end
   end
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            mem_req,
   input logic            mem_we,
   input logic [XLEN-1:0] mem_addr,
   input logic [1:0]      mem_size,
   input logic [XLEN-1:0] mem_wdata,
   input logic            mem_rsp_valid,
   input logic            res_valid,
   input logic            res_trap,
   input logic            res_wb_en,
   input logic            resv_valid,
   input logic            cur_is_sc
);
   logic [2:0] lo_mask;
   logic       upper_zero;

   always_comb begin
      case (mem_size)
         2'd0:    lo_mask = 3'b000;
         2'd1:    lo_mask = 3'b001;
         2'd2:    lo_mask = 3'b011;
         default: lo_mask = 3'b111;
      endcase
      if (mem_size == 2'd3) upper_zero = 1'b1;
      else                  upper_zero = ((mem_wdata >> (8 << mem_size)) == '0);
   end

   p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

   p_busy_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr[2:0] & lo_mask) == 3'b000));

   p_trap_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !(res_trap && res_wb_en));

   p_store_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> upper_zero);

   p_sc_drops_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && cur_is_sc |-> !resv_valid);

   p_res_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid || !$past(busy));
endmodule

bind lrsc_unit lrsc_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_size      (mem_size),
   .mem_wdata     (mem_wdata),
   .mem_rsp_valid (mem_rsp_valid),
   .res_valid     (res_valid),
   .res_trap      (res_trap),
   .res_wb_en     (res_wb_en),
   .resv_valid    (resv_valid),
   .cur_is_sc     (cur_is_sc)
);

// File: tb/sim_lrsc_unit.sv
module sim_lrsc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_is_sc = 1'b0, req_aq = 1'b0, req_rl = 1'b0;
   logic [1:0]  req_width = 2'd0;
   logic [63:0] req_addr = '0, req_wdata = '0;
   logic [4:0]  req_rd = '0;
   logic        busy, resv_clear = 1'b0;
   logic        mem_req, mem_we, mem_acq, mem_rel;
   logic [63:0] mem_addr, mem_wdata;
   logic [1:0]  mem_size;
   logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0, mem_rsp_done = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        res_valid, res_trap, res_wb_en;
   logic [3:0]  res_cause;
   logic [63:0] res_tval, res_wdata;
   logic [4:0]  res_rd;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   lrsc_unit #(.XLEN(64), .RD_W(5)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sc(req_is_sc),
      .req_width(req_width), .req_aq(req_aq), .req_rl(req_rl), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_rd(req_rd), .busy(busy), .resv_clear(resv_clear),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_acq(mem_acq), .mem_rel(mem_rel),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_done(mem_rsp_done),
      .mem_rdata(mem_rdata), .res_valid(res_valid), .res_trap(res_trap),
      .res_cause(res_cause), .res_tval(res_tval), .res_wb_en(res_wb_en),
      .res_rd(res_rd), .res_wdata(res_wdata)
   );

   // narrow variant for the XLEN=32 illegal-width case
   logic        n_req_valid = 1'b0;
   logic [31:0] n_mem_addr, n_mem_wdata, n_res_tval, n_res_wdata;
   logic        n_busy, n_mem_req, n_mem_we, n_mem_acq, n_mem_rel;
   logic        n_res_valid, n_res_trap, n_res_wb_en;
   logic [1:0]  n_mem_size;
   logic [3:0]  n_res_cause;
   logic [4:0]  n_res_rd;

   lrsc_unit #(.XLEN(32), .RD_W(5)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(n_req_valid), .req_is_sc(1'b0),
      .req_width(2'd3), .req_aq(1'b0), .req_rl(1'b0), .req_addr(32'h0000_0040),
      .req_wdata(32'h0), .req_rd(5'd9), .busy(n_busy), .resv_clear(1'b0),
      .mem_req(n_mem_req), .mem_we(n_mem_we), .mem_addr(n_mem_addr), .mem_size(n_mem_size),
      .mem_wdata(n_mem_wdata), .mem_acq(n_mem_acq), .mem_rel(n_mem_rel),
      .mem_rsp_valid(1'b0), .mem_rsp_err(1'b0), .mem_rsp_done(1'b0),
      .mem_rdata(32'h0), .res_valid(n_res_valid), .res_trap(n_res_trap),
      .res_cause(n_res_cause), .res_tval(n_res_tval), .res_wb_en(n_res_wb_en),
      .res_rd(n_res_rd), .res_wdata(n_res_wdata)
   );

   task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   function automatic logic [63:0] sext(logic [1:0] w, logic [63:0] v);
      case (w)
         2'd0:    return {{56{v[7]}}, v[7:0]};
         2'd1:    return {{48{v[15]}}, v[15:0]};
         2'd2:    return {{32{v[31]}}, v[31:0]};
         default: return v;
      endcase
   endfunction

   function automatic logic [63:0] lowpart(logic [1:0] w, logic [63:0] v);
      case (w)
         2'd0:    return {56'd0, v[7:0]};
         2'd1:    return {48'd0, v[15:0]};
         2'd2:    return {32'd0, v[31:0]};
         default: return v;
      endcase
   endfunction

   // one operation: offer, optionally answer memory after 'dly' wait cycles, check result
   task automatic run_op(string req, bit sc, logic [1:0] w, bit aq, bit rl,
                         logic [63:0] addr, logic [63:0] wd, logic [4:0] rd,
                         bit exp_mem, int dly, bit r_err, bit r_done, logic [63:0] r_data,
                         bit exp_trap, logic [3:0] exp_cause, logic [63:0] exp_val);
      @(negedge clk);
      req_valid = 1'b1; req_is_sc = sc; req_width = w; req_aq = aq; req_rl = rl;
      req_addr = addr; req_wdata = wd; req_rd = rd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req, "mem_req after accept", 64'(mem_req), 64'(exp_mem));
      if (exp_mem) begin
         chk(req, "mem_addr", mem_addr, addr);
         chk(req, "mem_we", 64'(mem_we), 64'(sc));
         chk("R8", "mem_size", 64'(mem_size), 64'(w));
         chk("R9", "mem_acq", 64'(mem_acq), 64'(sc ? (aq & rl) : aq));
         chk("R9", "mem_rel", 64'(mem_rel), 64'(sc ? rl : (aq & rl)));
         if (sc) chk("R8", "mem_wdata", mem_wdata, lowpart(w, wd));
         chk("R12", "busy", 64'(busy), 64'd1);
         for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R12", "mem_req held", 64'(mem_req), 64'd1);
            chk("R12", "res_valid quiet", 64'(res_valid), 64'd0);
         end
         mem_rsp_valid = 1'b1; mem_rsp_err = r_err; mem_rsp_done = r_done; mem_rdata = r_data;
         @(negedge clk);
         mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_done = 1'b0;
         chk("R12", "mem_req dropped", 64'(mem_req), 64'd0);
      end
      chk(req, "res_valid", 64'(res_valid), 64'd1);
      chk(req, "res_trap", 64'(res_trap), 64'(exp_trap));
      chk(req, "res_wb_en", 64'(res_wb_en), 64'(!exp_trap));
      if (exp_trap) begin
         chk(req, "res_cause", 64'(res_cause), 64'(exp_cause));
         chk(req, "res_tval", res_tval, addr);
      end else begin
         chk(req, "res_rd", 64'(res_rd), 64'(rd));
         chk(req, "res_wdata", res_wdata, exp_val);
      end
      @(negedge clk);
      chk("R12", "res_valid one cycle", 64'(res_valid), 64'd0);
   endtask

   task automatic t_reset();
      chk("R12", "reset res_valid", 64'(res_valid), 64'd0);
      chk("R12", "reset mem_req", 64'(mem_req), 64'd0);
      chk("R12", "reset busy", 64'(busy), 64'd0);
   endtask

   task automatic t_misaligned();
      run_op("R1", 0, 2'd1, 0, 0, 64'h101, 0, 5'd1, 0, 0, 0, 0, 0, 1, 4'd4, 0);
      run_op("R1", 0, 2'd2, 0, 0, 64'h102, 0, 5'd1, 0, 0, 0, 0, 0, 1, 4'd4, 0);
      run_op("R1", 0, 2'd3, 0, 0, 64'h104, 0, 5'd1, 0, 0, 0, 0, 0, 1, 4'd4, 0);
      run_op("R2", 1, 2'd2, 0, 0, 64'h106, 0, 5'd2, 0, 0, 0, 0, 0, 1, 4'd6, 0);
   endtask

   task automatic t_no_resv();
      run_op("R3", 1, 2'd2, 0, 0, 64'h180, 64'h5, 5'd3, 0, 0, 0, 0, 0, 0, 0, 64'd1);
   endtask

   task automatic t_load_ext();
      run_op("R6", 0, 2'd0, 1, 1, 64'h203, 0, 5'd4, 1, 0, 0, 0, 64'hAA80, 0, 0, sext(2'd0, 64'hAA80));
      run_op("R6", 0, 2'd1, 1, 0, 64'h206, 0, 5'd5, 1, 1, 0, 0, 64'h12347FFF, 0, 0, sext(2'd1, 64'h12347FFF));
      run_op("R6", 0, 2'd2, 0, 1, 64'h208, 0, 5'd6, 1, 0, 0, 0, 64'h9_8000_0001, 0, 0, sext(2'd2, 64'h9_8000_0001));
   endtask

   task automatic t_sc_success();
      run_op("R6", 0, 2'd2, 0, 0, 64'h300, 0, 5'd7, 1, 0, 0, 0, 64'h55, 0, 0, 64'h55);
      run_op("R4", 1, 2'd2, 0, 1, 64'h300, 64'h1122334455667788, 5'd8, 1, 2, 0, 1, 0, 0, 0, 64'd0);
      run_op("R5", 1, 2'd2, 0, 0, 64'h300, 64'h1, 5'd8, 0, 0, 0, 0, 0, 0, 0, 64'd1);
   endtask

   task automatic t_sc_not_done();
      run_op("R6", 0, 2'd3, 1, 1, 64'h400, 0, 5'd9, 1, 0, 0, 0, 64'hF000_0000_0000_0001, 0, 0, 64'hF000_0000_0000_0001);
      run_op("R4", 1, 2'd3, 1, 1, 64'h400, 64'hDEAD_BEEF_0000_1234, 5'd10, 1, 0, 0, 0, 0, 0, 0, 64'd1);
      run_op("R5", 1, 2'd3, 0, 0, 64'h400, 64'h0, 5'd10, 0, 0, 0, 0, 0, 0, 0, 64'd1);
   endtask

   task automatic t_sc_byte_half();
      run_op("R6", 0, 2'd0, 0, 0, 64'h451, 0, 5'd11, 1, 0, 0, 0, 64'h7F, 0, 0, 64'h7F);
      run_op("R8", 1, 2'd0, 1, 0, 64'h451, 64'hFFFF_FFFF_FFFF_FFA5, 5'd12, 1, 0, 0, 1, 0, 0, 0, 64'd0);
      run_op("R6", 0, 2'd1, 0, 0, 64'h462, 0, 5'd11, 1, 0, 0, 0, 64'h1, 0, 0, 64'h1);
      run_op("R8", 1, 2'd1, 1, 1, 64'h462, 64'h0123_4567_89AB_CDEF, 5'd12, 1, 0, 0, 1, 0, 0, 0, 64'd0);
   endtask

   task automatic t_addr_mismatch();
      run_op("R6", 0, 2'd2, 0, 0, 64'h500, 0, 5'd13, 1, 0, 0, 0, 64'h1, 0, 0, 64'h1);
      run_op("R13", 1, 2'd2, 0, 0, 64'h504, 64'h9, 5'd14, 0, 0, 0, 0, 0, 0, 0, 64'd1);
   endtask

   task automatic t_ext_clear();
      run_op("R6", 0, 2'd2, 0, 0, 64'h600, 0, 5'd15, 1, 0, 0, 0, 64'h2, 0, 0, 64'h2);
      @(negedge clk); resv_clear = 1'b1;
      @(negedge clk); resv_clear = 1'b0;
      run_op("R10", 1, 2'd2, 0, 0, 64'h600, 64'h3, 5'd16, 0, 0, 0, 0, 0, 0, 0, 64'd1);
   endtask

   task automatic t_faults();
      run_op("R7", 0, 2'd2, 0, 0, 64'h700, 0, 5'd17, 1, 0, 1, 0, 0, 1, 4'd5, 0);
      run_op("R7", 1, 2'd2, 0, 0, 64'h700, 64'h4, 5'd18, 0, 0, 0, 0, 0, 0, 0, 64'd1);
      run_op("R6", 0, 2'd3, 0, 0, 64'h800, 0, 5'd19, 1, 0, 0, 0, 64'h8, 0, 0, 64'h8);
      run_op("R7", 1, 2'd3, 0, 0, 64'h800, 64'h4, 5'd20, 1, 1, 1, 0, 0, 1, 4'd7, 0);
   endtask

   task automatic t_narrow_double();
      @(negedge clk); n_req_valid = 1'b1;
      @(negedge clk); n_req_valid = 1'b0;
      chk("R11", "narrow res_valid", 64'(n_res_valid), 64'd1);
      chk("R11", "narrow res_trap", 64'(n_res_trap), 64'd1);
      chk("R11", "narrow cause", 64'(n_res_cause), 64'd2);
      chk("R11", "narrow tval", 64'(n_res_tval), 64'd0);
      chk("R11", "narrow mem_req", 64'(n_mem_req), 64'd0);
      chk("R11", "narrow wb", 64'(n_res_wb_en), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_misaligned();
      t_no_resv();
      t_load_ext();
      t_sc_success();
      t_sc_not_done();
      t_sc_byte_half();
      t_addr_mismatch();
      t_ext_clear();
      t_faults();
      t_narrow_double();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end
endmodule